// File: doc/BRIEF.md
# Register-Mapped Synthesizer Configuration Port Bridge

This block sits on a simple 32-bit register bus and turns software accesses into single 16-bit transactions on the reconfiguration port of a clock synthesizer. Software first checks that the bridge is idle. It then writes one command word that holds the direction, a 7-bit port address and 16 bits of write data. The bridge issues a one-cycle request on the port and stays busy until the port raises its ready strobe. For a read, the data the port returns is captured and can be fetched from the status word once busy has cleared.

Two more registers sit beside the port bridge. The run register takes the synthesizer core out of reset and, together with that bit, enables the synthesizer. The reference-select register picks one of up to two reference clock inputs. Bus reads return their data one cycle after the read strobe.

Top module: `rcfg_port_bridge`

## Requirements
- R1: After a synchronous active-low reset, core_run, synth_en, ref_sel, port_en and port_we are 0, the status busy flag is 0, and the run, reference-select and status registers all read as zero.
- R2: Offset 0x40 is the run register. Bit 0 drives core_run and reads back in bit 0. Bit 1 is stored and reads back in bit 1. synth_en is high only while bits 0 and 1 are both set.
- R3: Offset 0x44 is the reference-select register. Bit 0 of a write is stored, drives ref_sel and reads back in bit 0. All other written bits are dropped.
- R4: A write to offset 0x70 with bit 29 set, made while idle, raises port_en for exactly one cycle, starting in the cycle after the write. In that cycle port_addr equals bits 22:16 of the word and port_wdata equals bits 15:0. port_we is high in the same cycle only when bit 28 is clear. Bits 27:23 have no effect.
- R5: Bit 16 of the status word at offset 0x74 is the busy flag. It is set from the cycle in which port_en rises. It clears on the first clock edge at which port_rdy is sampled high.
- R6: For a transaction with bit 28 set, port_rdata is captured when port_rdy is sampled high and appears in bits 15:0 of the status word. A write transaction leaves those bits unchanged.
- R7: A launch write made while busy is ignored. No port request is issued, and the pending transaction and the port contents are unaffected.
- R8: A write to offset 0x70 with bit 29 clear starts no transaction and leaves busy at 0.
- R9: port_rdy seen while idle changes neither the busy flag nor the captured read data.
- R10: reg_rdata is registered and valid in the cycle after reg_rd. The command offset 0x70 and every unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| core_run | output | 1 | Releases the synthesizer core from reset |
| synth_en | output | 1 | Synthesizer enable, gated by core_run |
| ref_sel | output | 1 | Reference clock index |
| port_en | output | 1 | One-cycle port request strobe |
| port_we | output | 1 | Port write qualifier, valid with port_en |
| port_addr | output | 7 | Port register address |
| port_wdata | output | 16 | Port write data |
| port_rdata | input | 16 | Port read data, valid with port_rdy |
| port_rdy | input | 1 | Port completion strobe |

## Verification
A port model holds a 128-entry array and answers each request after a delay of one to ten cycles. Port writes are followed by reads of the same address. This separates a correct data path from a swapped or stale capture, and a long delay shows that busy follows the ready strobe rather than a fixed latency. The command word is also tried with spare bits 27:23 set, with the launch bit clear, and as a second launch while the first is still pending. A stray ready strobe while idle shows whether capture is gated by an outstanding transaction.

// File: rtl/rcfg_bridge_pkg.sv
// Package: register offsets and command/status field positions shared by
// the configuration port bridge. Assumes byte offsets on an 8-bit bus address.
package rcfg_bridge_pkg;
    localparam logic [7:0] OFS_RUN    = 8'h40;
    localparam logic [7:0] OFS_REFSEL = 8'h44;
    localparam logic [7:0] OFS_CMD    = 8'h70;
    localparam logic [7:0] OFS_STAT   = 8'h74;

    localparam int CMD_GO_BIT    = 29;
    localparam int CMD_RD_BIT    = 28;
    localparam int CMD_ADDR_LSB  = 16;
    localparam int STAT_BUSY_BIT = 16;

    localparam int RUN_CORE_BIT  = 0;
    localparam int RUN_SYNTH_BIT = 1;
endpackage

// File: rtl/rcfg_csr_decode.sv
// Module: register decode for the bridge. It holds the run and reference
// select registers, recognises launch writes to the command offset and
// returns registered read data. It assumes one bus access per cycle and
// at least two reference inputs when REF_NUM > 1.
module rcfg_csr_decode
    import rcfg_bridge_pkg::*;
#(
    parameter int BUS_AW  = 8,
    parameter int BUS_DW  = 32,
    parameter int PORT_AW = 7,
    parameter int PORT_DW = 16,
    parameter int REF_NUM = 2,
    localparam int REF_W  = (REF_NUM > 1) ? $clog2(REF_NUM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic               core_run,
    output logic               synth_en,
    output logic [REF_W-1:0]   ref_sel,
    output logic               launch,
    output logic               launch_rd,
    output logic [PORT_AW-1:0] launch_addr,
    output logic [PORT_DW-1:0] launch_wdata,
    input  logic               busy,
    input  logic [PORT_DW-1:0] rd_data
);
    logic [1:0]        run_q;
    logic [REF_W-1:0]  ref_q;
    logic [BUS_DW-1:0] rdata_n;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[BUS_DW-1:CMD_GO_BIT+1],
                            bus_wdata[CMD_RD_BIT-1:CMD_ADDR_LSB+PORT_AW]};

    // Purpose: hold the run register bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (bus_wr && bus_addr == OFS_RUN)
            run_q <= bus_wdata[1:0];
    end

    assign core_run = run_q[RUN_CORE_BIT];
    assign synth_en = run_q[RUN_SYNTH_BIT] & run_q[RUN_CORE_BIT];

    // Reference select: stored only when a choice exists.
    generate
        if (REF_NUM > 1) begin : g_refsel
            // Purpose: hold the reference select index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ref_q <= '0;
                else if (bus_wr && bus_addr == OFS_REFSEL)
                    ref_q <= bus_wdata[REF_W-1:0];
            end
        end else begin : g_single_ref
            assign ref_q = '0;
        end
    endgenerate

    assign ref_sel = ref_q;

    // Purpose: decode a launch request from a command write.
    always_comb begin
        launch       = bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_GO_BIT];
        launch_rd    = bus_wdata[CMD_RD_BIT];
        launch_addr  = bus_wdata[CMD_ADDR_LSB +: PORT_AW];
        launch_wdata = bus_wdata[PORT_DW-1:0];
    end

    // Purpose: select read data for the addressed register.
    always_comb begin
        rdata_n = '0;
        case (bus_addr)
            OFS_RUN:    rdata_n[1:0] = run_q;
            OFS_REFSEL: rdata_n[REF_W-1:0] = ref_q;
            OFS_STAT: begin
                rdata_n[STAT_BUSY_BIT]  = busy;
                rdata_n[PORT_DW-1:0]    = rd_data;
            end
            default:    rdata_n = '0;
        endcase
    end

    // Purpose: register read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rdata_n;
    end

    AST_SYNTH_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        synth_en |-> core_run); // R2
    AST_REFSEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ref_sel) < ((REF_NUM > 1) ? REF_NUM : 1)); // R3
endmodule

// File: rtl/rcfg_port_seq.sv
// Module: port transaction sequencer. It accepts one request while idle,
// issues a single-cycle port strobe, and stays busy until the ready strobe,
// capturing read data for read requests. It assumes the port answers no
// earlier than the cycle after the strobe.
module rcfg_port_seq #(
    parameter int PORT_AW = 7,
    parameter int PORT_DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_rd,
    input  logic [PORT_AW-1:0] req_addr,
    input  logic [PORT_DW-1:0] req_data,
    output logic               port_en,
    output logic               port_we,
    output logic [PORT_AW-1:0] port_addr,
    output logic [PORT_DW-1:0] port_wdata,
    input  logic [PORT_DW-1:0] port_rdata,
    input  logic               port_rdy,
    output logic               busy,
    output logic [PORT_DW-1:0] rd_data
);
    logic rd_pend;

    // Purpose: launch, track and complete one port transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en    <= 1'b0;
            port_we    <= 1'b0;
            port_addr  <= '0;
            port_wdata <= '0;
            busy       <= 1'b0;
            rd_pend    <= 1'b0;
            rd_data    <= '0;
        end else begin
            port_en <= 1'b0;
            port_we <= 1'b0;
            if (req_valid && !busy) begin
                port_en    <= 1'b1;
                port_we    <= !req_rd;
                port_addr  <= req_addr;
                port_wdata <= req_data;
                busy       <= 1'b1;
                rd_pend    <= req_rd;
            end else if (busy && port_rdy) begin
                busy <= 1'b0;
                if (rd_pend)
                    rd_data <= port_rdata;
            end
        end
    end

    AST_EN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> !port_en); // R4
    AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |-> port_en); // R4
    AST_EN_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> busy); // R5
    AST_RDY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && port_rdy) |=> !busy); // R5
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !port_en); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(port_addr)); // R4
    AST_IDLE_RDY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data)); // R9
endmodule

// File: rtl/rcfg_port_bridge.sv
// Module: top of the register-mapped configuration port bridge. It joins
// the register decode with the port sequencer. It assumes software polls
// the busy flag before each command write.
module rcfg_port_bridge #(
    parameter int BUS_AW  = 8,
    parameter int BUS_DW  = 32,
    parameter int PORT_AW = 7,
    parameter int PORT_DW = 16,
    parameter int REF_NUM = 2,
    localparam int REF_W  = (REF_NUM > 1) ? $clog2(REF_NUM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [BUS_AW-1:0]  reg_addr,
    input  logic [BUS_DW-1:0]  reg_wdata,
    output logic [BUS_DW-1:0]  reg_rdata,
    output logic               core_run,
    output logic               synth_en,
    output logic [REF_W-1:0]   ref_sel,
    output logic               port_en,
    output logic               port_we,
    output logic [PORT_AW-1:0] port_addr,
    output logic [PORT_DW-1:0] port_wdata,
    input  logic [PORT_DW-1:0] port_rdata,
    input  logic               port_rdy
);
    logic               launch;
    logic               launch_rd;
    logic [PORT_AW-1:0] launch_addr;
    logic [PORT_DW-1:0] launch_wdata;
    logic               busy;
    logic [PORT_DW-1:0] rd_data;

    rcfg_csr_decode #(
        .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .PORT_AW(PORT_AW),
        .PORT_DW(PORT_DW), .REF_NUM(REF_NUM)
    ) u_csr (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(reg_wr), .bus_rd(reg_rd), .bus_addr(reg_addr),
        .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
        .core_run(core_run), .synth_en(synth_en), .ref_sel(ref_sel),
        .launch(launch), .launch_rd(launch_rd), .launch_addr(launch_addr),
        .launch_wdata(launch_wdata), .busy(busy), .rd_data(rd_data)
    );

    rcfg_port_seq #(
        .PORT_AW(PORT_AW), .PORT_DW(PORT_DW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(launch), .req_rd(launch_rd), .req_addr(launch_addr),
        .req_data(launch_wdata),
        .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .port_rdy(port_rdy),
        .busy(busy), .rd_data(rd_data)
    );
endmodule

// File: tb/rcfg_port_bridge_tb.sv
module rcfg_port_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_run, synth_en;
    logic [0:0]  ref_sel;
    logic        port_en, port_we;
    logic [6:0]  port_addr;
    logic [15:0] port_wdata, port_rdata;
    logic        port_rdy;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    rcfg_port_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_run(core_run), .synth_en(synth_en), .ref_sel(ref_sel),
        .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .port_rdy(port_rdy)
    );

    // Port model: array with a programmable reply delay.
    logic [15:0] pmem [128];
    logic        m_rdy = 1'b0, pend = 1'b0, stray = 1'b0;
    logic [15:0] m_rdata = '0;
    logic [6:0]  paddr = '0;
    int          cnt = 0, next_delay = 1;

    assign port_rdy   = m_rdy | stray;
    assign port_rdata = stray ? 16'hDEAD : m_rdata;

    always @(posedge clk) begin
        m_rdy <= 1'b0;
        if (port_en) begin
            if (port_we) pmem[port_addr] <= port_wdata;
            paddr <= port_addr;
            cnt   <= next_delay;
            pend  <= 1'b1;
        end else if (pend) begin
            if (cnt <= 1) begin
                m_rdy   <= 1'b1;
                m_rdata <= pmem[paddr];
                pend    <= 1'b0;
            end else cnt <= cnt - 1;
        end
    end

    typedef struct packed { logic we; logic [6:0] addr; logic [15:0] data; } txn_t;
    txn_t exp_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop expected port requests as they appear.
    always @(negedge clk) begin
        if (rst_n && port_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected port request", {8'h0, port_we, port_addr, port_wdata}, 32'h0);
            end else begin
                txn_t e;
                e = exp_q.pop_front();
                check(port_we == e.we && port_addr == e.addr && (!e.we || port_wdata == e.data),
                      "R4 port request", {8'h0, port_we, port_addr, port_wdata}, {8'h0, e});
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            bus_read(8'h74, s);
            if (!s[16]) return;
        end
        check(1'b0, "R5 busy never cleared", s, 32'h0);
    endtask

    task automatic port_op(input bit rd, input logic [6:0] a, input logic [15:0] d, input int dly);
        txn_t e;
        next_delay = dly;
        e.we = !rd; e.addr = a; e.data = d;
        exp_q.push_back(e);
        bus_write(8'h70, (32'h1 << 29) | (rd ? (32'h1 << 28) : 32'h0) | (32'(a) << 16) | 32'(d));
    endtask

    logic [31:0] rv;

    initial begin
        for (int i = 0; i < 128; i++) pmem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(!core_run && !synth_en && ref_sel == 0 && !port_en && !port_we, "R1 outputs",
              {27'h0, core_run, synth_en, ref_sel, port_en, port_we}, 32'h0);
        bus_read(8'h40, rv); check(rv == 0, "R1 run reg", rv, 0);
        bus_read(8'h44, rv); check(rv == 0, "R1 refsel reg", rv, 0);
        bus_read(8'h74, rv); check(rv == 0, "R1 status reg", rv, 0);

        // R2 run register
        bus_write(8'h40, 32'h2);
        check(!synth_en && !core_run, "R2 bit1 alone", {30'h0, core_run, synth_en}, 0);
        bus_read(8'h40, rv); check(rv == 32'h2, "R2 readback", rv, 32'h2);
        bus_write(8'h40, 32'h3);
        check(synth_en && core_run, "R2 both set", {30'h0, core_run, synth_en}, 32'h3);
        bus_write(8'h40, 32'h1);
        check(!synth_en && core_run, "R2 run only", {30'h0, core_run, synth_en}, 32'h2);
        bus_write(8'h40, 32'h3);

        // R3 reference select
        bus_write(8'h44, 32'h1);
        check(ref_sel == 1, "R3 sel out", 32'(ref_sel), 1);
        bus_read(8'h44, rv); check(rv == 1, "R3 readback", rv, 1);
        bus_write(8'h44, 32'hFFFF_FFFE);
        bus_read(8'h44, rv); check(rv == 0 && ref_sel == 0, "R3 upper bits dropped", rv, 0);

        // R4/R5 port write, busy seen right after launch
        port_op(1'b0, 7'h15, 16'hBEEF, 3);
        bus_read(8'h74, rv); check(rv[16] == 1'b1, "R5 busy after launch", rv, 32'h10000);
        wait_idle();
        bus_read(8'h74, rv); check(rv[15:0] == 16'h0, "R6 write leaves data", rv, 0);

        // R6 read back, varied delays and addresses
        port_op(1'b1, 7'h15, 16'h0, 1); wait_idle();
        bus_read(8'h74, rv); check(rv == 32'h0000_BEEF, "R6 read 0x15", rv, 32'hBEEF);
        port_op(1'b0, 7'h00, 16'h1234, 2); wait_idle();
        port_op(1'b0, 7'h7F, 16'hA5A5, 4); wait_idle();
        port_op(1'b1, 7'h00, 16'h0, 4); wait_idle();
        bus_read(8'h74, rv); check(rv[15:0] == 16'h1234, "R6 read 0x00", rv, 32'h1234);
        port_op(1'b1, 7'h7F, 16'h0, 2); wait_idle();
        bus_read(8'h74, rv); check(rv[15:0] == 16'hA5A5, "R6 read 0x7F", rv, 32'hA5A5);

        // R4 spare bits 27:23 have no effect on the address
        next_delay = 1;
        exp_q.push_back('{we: 1'b0, addr: 7'h55, data: 16'h0});
        bus_write(8'h70, 32'h3F80_0000 | (32'h55 << 16));
        wait_idle();

        // R8 command without the launch bit
        bus_write(8'h70, (32'h10 << 16) | 32'h5555);
        bus_read(8'h74, rv); check(rv[16] == 1'b0, "R8 no busy", rv, 0);
        port_op(1'b1, 7'h10, 16'h0, 1); wait_idle();
        bus_read(8'h74, rv); check(rv[15:0] == 16'h0, "R8 port untouched", rv, 0);

        // R7 launch while busy ignored (long reply delay)
        port_op(1'b1, 7'h7F, 16'h0, 10);
        bus_write(8'h70, (32'h1 << 29) | (32'h7F << 16));
        wait_idle();
        bus_read(8'h74, rv); check(rv[15:0] == 16'hA5A5, "R7 pending read intact", rv, 32'hA5A5);
        port_op(1'b1, 7'h7F, 16'h0, 1); wait_idle();
        bus_read(8'h74, rv); check(rv[15:0] == 16'hA5A5, "R7 port not written", rv, 32'hA5A5);

        // R9 stray ready while idle
        stray = 1'b1; @(negedge clk); stray = 1'b0;
        bus_read(8'h74, rv); check(rv == 32'h0000_A5A5, "R9 stray ready ignored", rv, 32'hA5A5);

        // R10 command and unmapped offsets read zero
        bus_read(8'h70, rv); check(rv == 0, "R10 cmd reads zero", rv, 0);
        bus_read(8'h48, rv); check(rv == 0, "R10 unmapped 0x48", rv, 0);
        bus_read(8'h00, rv); check(rv == 0, "R10 unmapped 0x00", rv, 0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4 all requests seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule